// File: doc/BRIEF.md
# Pipelined Carry Resolution Unit

This block sits behind the inverse number-theoretic transform of a large-integer multiplier. After the point-wise products are transformed back, each output coefficient is a 64-bit value that is wider than one digit of the product. The coefficient in lane `i` carries weight `B^i`, where the digit base is `B = 2^DIG_W`. The unit accepts a group of `LANES` such coefficients in a cycle. Two cycles later it emits `LANES` final digits of the product. Those digits are already reduced below `B`, and all carries across the group have been resolved.

Coefficient bits beyond the top digit of a group are not lost. They are held in a saved-overflow register, and the same happens to the final carry out of the top digit. The saved value is added into the lowest two digits of the next group. A start marker on the first group of a product zeroes that register. Once the last group has been sent, an end strobe sends a flush beat through the pipeline. The flush beat emits the remaining saved value as high digits and raises a final flag.

The first pipeline stage builds the column sums. It splits each sum into a digit and a small excess, and it forms generate and propagate flags. The second stage adds the saved overflow, runs the look-ahead carries across the lanes and registers the digits. The parameters must satisfy `COEF_W < 3*DIG_W`, `DIG_W >= 4` and `LANES >= 2`.

Top module: `carry_resolve_unit`

## Requirements
- R1: While reset is high, and after it until the first accepted beat, `out_valid` and `out_final` are 0.
- R2: A beat is accepted in a cycle where `in_valid` or `in_end` is high. Its result appears with `out_valid` = 1 exactly two clock edges later. Back-to-back beats give back-to-back results with no stall.
- R3: For a data beat, `out_digits[j*DIG_W +: DIG_W]` is digit `j` of `(S + sum_i c_i * B^i) mod B^LANES`. Here `c_i = in_coef[i*COEF_W +: COEF_W]` and `S` is the saved overflow.
- R4: Within a coefficient, bits `[DIG_W-1:0]` weigh at digit `i`, bits `[2*DIG_W-1:DIG_W]` weigh at digit `i+1`, and the remaining upper bits weigh at digit `i+2`.
- R5: After a data beat, the saved overflow becomes `floor((S + sum_i c_i * B^i) / B^LANES)`. That value is added at digit 0 of the next beat.
- R6: A data beat with `in_start` high treats `S` as 0, whatever the earlier groups left.
- R7: A cycle with neither `in_valid` nor `in_end` produces no output. It leaves the saved overflow unchanged, whatever `in_coef` holds.
- R8: A flush beat (`in_end` high, `in_valid` low) ignores `in_coef`. It outputs `S` as digits 0 and up with `out_final` = 1, and leaves the saved overflow at 0.
- R9: `out_final` is 1 only on flush results. When `in_valid` and `in_end` are both high, the beat is a data beat.
- R10: A carry that enters at digit 0 passes through every digit of the group in the same beat. When all digits are `B-1`, they become 0 and the carry goes into the saved overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A coefficient group is present |
| in_start | input | 1 | First group of a product; clears the saved overflow |
| in_end | input | 1 | Flush strobe after the last group |
| in_coef | input | LANES*COEF_W | Coefficient group, lane i at bits [i*COEF_W +: COEF_W] |
| out_valid | output | 1 | Result digits valid |
| out_final | output | 1 | Result comes from a flush beat |
| out_digits | output | LANES*DIG_W | Result digits, digit j at bits [j*DIG_W +: DIG_W] |

## Verification
The hardest case to reach is a carry that crosses both the group boundary and every lane at once. It needs the saved overflow to be non-zero at the same time as a group whose digits all sit at `B-1`. The stimulus builds it in two beats. First comes a group whose top lane holds exactly `B`, which leaves an overflow of 1. Then comes a group in which every lane holds `B-1`. Saturated all-ones groups with idle gaps, a restart in mid-stream, and a beat with valid and end together cover the remaining ordering cases. A behavioural big-integer model checks every cycle.

// File: rtl/cru_pkg.sv
package cru_pkg;

    localparam int DEF_LANES  = 16;
    localparam int DEF_DIG_W  = 24;
    localparam int DEF_COEF_W = 64;

    typedef enum logic [1:0] {
        BEAT_IDLE  = 2'd0,
        BEAT_DATA  = 2'd1,
        BEAT_FLUSH = 2'd2
    } beat_e;

    // valid takes priority over the flush strobe
    function automatic beat_e beat_of(input logic valid, input logic fin);
        if (valid)    return BEAT_DATA;
        else if (fin) return BEAT_FLUSH;
        else          return BEAT_IDLE;
    endfunction

endpackage

// File: rtl/cru_column.sv
module cru_column
    import cru_pkg::*;
#(
    parameter int LANES  = DEF_LANES,
    parameter int DIG_W  = DEF_DIG_W,
    parameter int COEF_W = DEF_COEF_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  beat_e                     in_kind,
    input  logic                      in_start,
    input  logic [LANES*COEF_W-1:0]   in_coef,
    output beat_e                     s1_kind,
    output logic                      s1_start,
    output logic [LANES*(DIG_W+1)-1:0] s1_t,
    output logic [LANES-1:0]          s1_g,
    output logic [LANES-1:0]          s1_p,
    output logic [2*DIG_W-1:0]        s1_ovf
);
    localparam int HI_W   = COEF_W - 2*DIG_W;
    localparam int COL_W  = DIG_W + 2;
    localparam int T_W    = DIG_W + 1;
    localparam int SAVE_W = 2*DIG_W;

    logic [LANES*COEF_W-1:0] coef_m;
    logic [DIG_W-1:0] lo_a [LANES];
    logic [DIG_W-1:0] md_a [LANES];
    logic [HI_W-1:0]  hi_a [LANES];
    logic [COL_W-1:0] col  [LANES];
    logic [T_W-1:0]   t_a  [LANES];
    logic [SAVE_W-1:0] ovf_c;

    assign coef_m = (in_kind == BEAT_DATA) ? in_coef : '0;

    for (genvar i = 0; i < LANES; i++) begin : g_split
        assign lo_a[i] = coef_m[i*COEF_W +: DIG_W];
        assign md_a[i] = coef_m[i*COEF_W + DIG_W +: DIG_W];
        assign hi_a[i] = coef_m[i*COEF_W + 2*DIG_W +: HI_W];
    end

    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            col[j] = COL_W'(lo_a[j]);
            if (j >= 1) col[j] = col[j] + COL_W'(md_a[j-1]);
            if (j >= 2) col[j] = col[j] + COL_W'(hi_a[j-2]);
        end
        for (int j = 0; j < LANES; j++) begin
            t_a[j] = T_W'(col[j][DIG_W-1:0]);
            if (j >= 1) t_a[j] = t_a[j] + T_W'(col[j-1][COL_W-1:DIG_W]);
        end
        ovf_c = SAVE_W'(col[LANES-1][COL_W-1:DIG_W]) + SAVE_W'(md_a[LANES-1])
              + SAVE_W'(hi_a[LANES-2]) + (SAVE_W'(hi_a[LANES-1]) << DIG_W);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_kind  <= BEAT_IDLE;
            s1_start <= 1'b0;
        end else begin
            s1_kind  <= in_kind;
            s1_start <= in_start && (in_kind != BEAT_IDLE);
        end
        for (int j = 0; j < LANES; j++) begin
            s1_t[j*T_W +: T_W] <= t_a[j];
            s1_g[j]            <= t_a[j][DIG_W];
            s1_p[j]            <= &t_a[j][DIG_W-1:0];
        end
        s1_ovf <= ovf_c;
    end

endmodule

// File: rtl/cru_resolve.sv
module cru_resolve
    import cru_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    parameter int DIG_W = DEF_DIG_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  beat_e                      s1_kind,
    input  logic                       s1_start,
    input  logic [LANES*(DIG_W+1)-1:0] s1_t,
    input  logic [LANES-1:0]           s1_g,
    input  logic [LANES-1:0]           s1_p,
    input  logic [2*DIG_W-1:0]         s1_ovf,
    output logic                       out_valid,
    output logic                       out_final,
    output logic [LANES*DIG_W-1:0]     out_digits
);
    localparam int T_W    = DIG_W + 1;
    localparam int TW     = DIG_W + 2;
    localparam int SAVE_W = 2*DIG_W;

    logic [SAVE_W-1:0]      saved_q, vin, save_nxt;
    logic [TW-1:0]          tw  [LANES];
    logic [LANES-1:0]       gen, prp;
    logic [LANES:0]         cy;
    logic [LANES*DIG_W-1:0] dig;

    always_comb begin
        vin = s1_start ? '0 : saved_q;
        for (int j = 0; j < LANES; j++) begin
            tw[j] = TW'(s1_t[j*T_W +: T_W]);
            if (j == 0) tw[j] = tw[j] + TW'(vin[DIG_W-1:0]);
            if (j == 1) tw[j] = tw[j] + TW'(vin[SAVE_W-1:DIG_W]);
            if (j < 2) begin
                gen[j] = |tw[j][TW-1:DIG_W];
                prp[j] = &tw[j][DIG_W-1:0];
            end else begin
                gen[j] = s1_g[j];
                prp[j] = s1_p[j];
            end
        end
        cy[0] = 1'b0;
        for (int j = 0; j < LANES; j++) begin
            cy[j+1] = gen[j] | (prp[j] & cy[j]);
        end
        for (int j = 0; j < LANES; j++) begin
            dig[j*DIG_W +: DIG_W] = tw[j][DIG_W-1:0] + DIG_W'(cy[j]);
        end
        save_nxt = s1_ovf + SAVE_W'(cy[LANES]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            saved_q   <= '0;
            out_valid <= 1'b0;
            out_final <= 1'b0;
        end else begin
            if (s1_kind != BEAT_IDLE) saved_q <= save_nxt;
            out_valid <= (s1_kind != BEAT_IDLE);
            out_final <= (s1_kind == BEAT_FLUSH);
        end
        out_digits <= dig;
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (s1_kind == BEAT_IDLE) |=> $stable(saved_q)); // R7
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (s1_kind == BEAT_FLUSH) |=> (saved_q == '0)); // R8
    AST_GP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        ((s1_g & s1_p) == '0)); // R10

endmodule

// File: rtl/carry_resolve_unit.sv
module carry_resolve_unit
    import cru_pkg::*;
#(
    parameter int LANES  = DEF_LANES,
    parameter int DIG_W  = DEF_DIG_W,
    parameter int COEF_W = DEF_COEF_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    in_start,
    input  logic                    in_end,
    input  logic [LANES*COEF_W-1:0] in_coef,
    output logic                    out_valid,
    output logic                    out_final,
    output logic [LANES*DIG_W-1:0]  out_digits
);
    beat_e                       kind, s1_kind;
    logic                        s1_start;
    logic [LANES*(DIG_W+1)-1:0]  s1_t;
    logic [LANES-1:0]            s1_g, s1_p;
    logic [2*DIG_W-1:0]          s1_ovf;

    assign kind = beat_of(in_valid, in_end);

    cru_column #(.LANES(LANES), .DIG_W(DIG_W), .COEF_W(COEF_W)) u_col (
        .clk(clk), .rst(rst), .in_kind(kind), .in_start(in_start),
        .in_coef(in_coef), .s1_kind(s1_kind), .s1_start(s1_start),
        .s1_t(s1_t), .s1_g(s1_g), .s1_p(s1_p), .s1_ovf(s1_ovf)
    );

    cru_resolve #(.LANES(LANES), .DIG_W(DIG_W)) u_res (
        .clk(clk), .rst(rst), .s1_kind(s1_kind), .s1_start(s1_start),
        .s1_t(s1_t), .s1_g(s1_g), .s1_p(s1_p), .s1_ovf(s1_ovf),
        .out_valid(out_valid), .out_final(out_final), .out_digits(out_digits)
    );

    AST_TWO_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (in_valid || in_end) |-> ##2 out_valid); // R2
    AST_FINAL_VALID: assert property (@(posedge clk) disable iff (rst)
        out_final |-> out_valid); // R9
    AST_DATA_NOT_FINAL: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 !out_final); // R9

endmodule

// File: tb/tb_carry_resolve_unit.sv
`timescale 1ns/1ps
module tb_carry_resolve_unit;
    localparam int L  = 16;
    localparam int DW = 24;
    localparam int CW = 64;
    localparam int MW = L*DW + CW + 2*DW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_start = 1'b0, in_end = 1'b0;
    logic [L*CW-1:0] in_coef = '0;
    logic out_valid, out_final;
    logic [L*DW-1:0] out_digits;

    always #4 clk = ~clk;

    carry_resolve_unit #(.LANES(L), .DIG_W(DW), .COEF_W(CW)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
        .in_end(in_end), .in_coef(in_coef), .out_valid(out_valid),
        .out_final(out_final), .out_digits(out_digits)
    );

    int n_checks = 0;
    int n_fail   = 0;

    logic [MW-1:0] vm = '0;
    logic e1_v = 0, e1_f = 0, e2_v = 0, e2_f = 0;
    logic [L*DW-1:0] e1_d = '0, e2_d = '0;
    string e1_tag = "R7", e2_tag = "R7";

    task automatic chk_bit(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic chk_vec(string tag, logic [L*DW-1:0] act, logic [L*DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare();
        chk_bit(e2_v ? "R2" : e2_tag, out_valid, e2_v);
        if (e2_v) begin
            chk_vec(e2_tag, out_digits, e2_d);
            chk_bit(e2_f ? "R8" : "R9", out_final, e2_f);
        end
    endtask

    task automatic drive(logic v, logic s, logic e, logic [L*CW-1:0] c, string tag);
        logic [MW-1:0] acc;
        @(negedge clk);
        compare();
        in_valid = v; in_start = s; in_end = e; in_coef = c;
        e2_v = e1_v; e2_f = e1_f; e2_d = e1_d; e2_tag = e1_tag;
        e1_v = v | e;
        e1_f = !v && e;
        e1_tag = tag;
        e1_d = '0;
        if (v | e) begin
            if (s) vm = '0;
            acc = vm;
            if (v) begin
                for (int i = 0; i < L; i++) acc = acc + (MW'(c[i*CW +: CW]) << (i*DW));
            end
            e1_d = acc[L*DW-1:0];
            vm = acc >> (L*DW);
        end
    endtask

    function automatic logic [L*CW-1:0] rnd_grp();
        logic [L*CW-1:0] r;
        for (int i = 0; i < L; i++) r[i*CW +: CW] = {$urandom, $urandom};
        return r;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        logic [L*CW-1:0] g;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk_bit("R1", out_valid, 1'b0);
        chk_bit("R1", out_final, 1'b0);
        rst = 1'b0;
        repeat (2) drive(0, 0, 0, '0, "R1");

        // R4: single coefficient with distinct fields in lane 3
        g = '0;
        g[3*CW +: CW] = {16'hABCD, 24'h123456, 24'h789ABC};
        drive(1, 1, 0, g, "R4");
        drive(0, 0, 1, rnd_grp(), "R8");
        g = '0;
        g[(L-1)*CW +: CW] = {16'hFFFF, 24'hFFFFFF, 24'hFFFFFF};
        drive(1, 1, 0, g, "R4");
        drive(0, 0, 1, '0, "R8");

        // R5 then R10: overflow of 1, then a full-length carry chain
        g = '0;
        g[(L-1)*CW +: CW] = 64'(1) << DW;
        drive(1, 1, 0, g, "R5");
        g = '0;
        for (int i = 0; i < L; i++) g[i*CW +: CW] = 64'((1 << DW) - 1);
        drive(1, 0, 0, g, "R10");
        drive(1, 0, 0, g, "R10");
        drive(0, 0, 1, '0, "R8");

        // R3/R2: random back-to-back groups
        for (int k = 0; k < 20; k++) drive(1, k == 0, 0, rnd_grp(), "R3");
        drive(0, 0, 1, '0, "R8");

        // R3/R7: saturated groups separated by idle cycles with junk
        for (int k = 0; k < 4; k++) begin
            drive(1, k == 0, 0, '1, "R3");
            drive(0, 0, 0, rnd_grp(), "R7");
            drive(0, 0, 0, '1, "R7");
        end
        drive(0, 0, 1, '1, "R8");

        // R6: restart in mid-stream discards the overflow
        drive(1, 1, 0, '1, "R5");
        drive(1, 0, 0, '1, "R5");
        drive(1, 1, 0, rnd_grp(), "R6");
        drive(1, 0, 0, '1, "R6");
        drive(0, 0, 1, '0, "R8");

        // R9: valid with end is a data beat
        drive(1, 1, 0, '1, "R9");
        drive(1, 0, 1, rnd_grp(), "R9");
        drive(0, 0, 1, '0, "R8");
        drive(0, 0, 1, '0, "R8");

        repeat (4) drive(0, 0, 0, '0, "R7");
        summary();
        $finish;
    end

endmodule